// File: doc/BRIEF.md
# Oldest-First Ready Instruction Selector

This block is the select stage of a unified instruction window. Each cycle it scans every window entry and picks one instruction to send to a functional unit. An entry qualifies when it holds a live instruction, neither source operand is waiting on a producer, it has not yet been dispatched or executed, and the unit class it needs is free. Among the entries that qualify, the one nearest the oldest pointer in program order wins.

The window storage, the oldest pointer and the wakeup logic that clears the operand locks all sit outside the block and arrive as inputs. In the same cycle the block returns a one-hot grant that the storage uses to set the chosen entry's dispatched flag. On the next clock edge an issue register presents the winner's tag and unit class to the functional units. For each source operand it also gives a select bit: one for the producer's window data, zero for the register file.

A store is held back until it is the oldest entry, so memory is written only from the in-order point. A flush in the same cycle blocks any dispatch.

Top module: `oldest_ready_sel`

## Requirements
- R1: An entry qualifies only when its valid bit is 1, both lock bits are 0, its dispatched and executed bits are 0, its unit class is 0 (integer ALU), 1 (load/store) or 2 (branch), and bit `class` of `fu_busy` is 0. Class 3 never qualifies.
- R2: Among the entries that qualify, the winner is the first one found when scanning from index `head_ptr` upward and wrapping from N-1 back to 0.
- R3: `grant` is combinational and has at most one bit set. That bit is the winner's index. `grant` is all zero when no entry qualifies.
- R4: In the clock edge after a nonzero `grant`, `iss_valid` becomes 1, `iss_tag` becomes the winner's index and `iss_fu` becomes the winner's unit class.
- R5: For each source operand, `iss_srcN_tag` carries the winner's producer index. `iss_srcN_win` is 1 only when the winner's has-producer flag is set and the entry at that producer index is valid. Otherwise it is 0, meaning a register file read.
- R6: An entry whose store bit is 1 qualifies only when its index equals `head_ptr`.
- R7: When no entry qualifies, the next edge clears `iss_valid`, and the tag, class and operand fields of the issue register keep their previous values.
- R8: While `flush` is 1, `grant` is all zero, and the next edge clears `iss_valid` with the other issue fields held.
- R9: While `rst_n` is low, every issue register output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Blocks dispatch this cycle |
| head_ptr | input | TW | Index of the oldest window entry |
| ent_valid | input | N | Entry holds a live instruction |
| ent_lock1 | input | N | First operand still awaits its producer |
| ent_lock2 | input | N | Second operand still awaits its producer |
| ent_disp | input | N | Entry already dispatched |
| ent_exec | input | N | Entry already executed |
| ent_store | input | N | Entry is a store |
| ent_fu | input | N x 2 | Unit class per entry (0 ALU, 1 load/store, 2 branch, 3 none) |
| ent_src1_has | input | N | First operand was renamed to a window producer |
| ent_src1_id | input | N x TW | Producer index of the first operand |
| ent_src2_has | input | N | Second operand was renamed to a window producer |
| ent_src2_id | input | N x TW | Producer index of the second operand |
| fu_busy | input | 3 | Busy flag per unit class, bit k for class k |
| grant | output | N | One-hot mark-dispatched strobe to the window |
| iss_valid | output | 1 | Issue register holds a new dispatch |
| iss_tag | output | TW | Window index of the dispatched entry |
| iss_fu | output | 2 | Unit class of the dispatched entry |
| iss_src1_win | output | 1 | First operand comes from window data (1) or register file (0) |
| iss_src1_tag | output | TW | Producer index for the first operand |
| iss_src2_win | output | 1 | Second operand comes from window data (1) or register file (0) |
| iss_src2_tag | output | TW | Producer index for the second operand |

## Verification
The bench builds the block with its default window of eight entries, so TW is three bits. With that size, random oldest pointers reach every wrap position of the age scan, and random producer indices hit both live and retired producers. Eight entries also make it common for a store to sit at the head and just as common for it to sit behind it. Directed cases cover the wrap from the last index to index 0, a unit class that is busy, the unused class 3, flush, an empty selection and a store at and away from the head.

// File: rtl/oldsel_pkg.sv
package oldsel_pkg;

  typedef enum logic [1:0] {
    FU_ALU  = 2'd0,
    FU_LSU  = 2'd1,
    FU_BRU  = 2'd2,
    FU_NONE = 2'd3
  } fu_cls_e;

  localparam int NUM_FU = 3;

  // Window slot visited at scan step 'step' when the scan starts at 'head'.
  function automatic int age_slot(input int head, input int step, input int depth);
    return (head + step) % depth;
  endfunction

  // Class usable when it names a real unit and that unit is free.
  function automatic logic fu_free(input logic [1:0] cls, input logic [NUM_FU-1:0] busy);
    logic [3:0] blocked;
    blocked = {1'b1, busy};
    return !blocked[cls];
  endfunction

endpackage

// File: rtl/oldsel_elig.sv
module oldsel_elig #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic [TW-1:0]          head_ptr,
  input  logic [N-1:0]           ent_valid,
  input  logic [N-1:0]           ent_lock1,
  input  logic [N-1:0]           ent_lock2,
  input  logic [N-1:0]           ent_disp,
  input  logic [N-1:0]           ent_exec,
  input  logic [N-1:0]           ent_store,
  input  logic [N-1:0][1:0]      ent_fu,
  input  logic [oldsel_pkg::NUM_FU-1:0] fu_busy,
  output logic [N-1:0]           ready
);
  import oldsel_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic ops_ok;
    logic life_ok;
    logic unit_ok;
    logic order_ok;

    assign ops_ok   = !ent_lock1[i] && !ent_lock2[i];
    assign life_ok  = ent_valid[i] && !ent_disp[i] && !ent_exec[i];
    assign unit_ok  = fu_free(ent_fu[i], fu_busy);
    assign order_ok = !ent_store[i] || (head_ptr == TW'(i));
    assign ready[i] = ops_ok && life_ok && unit_ok && order_ok;
  end

endmodule

// File: rtl/oldsel_pick.sv
module oldsel_pick #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]  ready,
  input  logic [TW-1:0] head_ptr,
  output logic          found,
  output logic [TW-1:0] win_idx,
  output logic [N-1:0]  win_oh
);
  import oldsel_pkg::*;

  always_comb begin
    logic [TW-1:0] slot;
    found   = 1'b0;
    win_idx = '0;
    slot    = '0;
    for (int k = 0; k < N; k++) begin
      slot = TW'(age_slot(int'(head_ptr), k, N));
      if (!found && ready[slot]) begin
        found   = 1'b1;
        win_idx = slot;
      end
    end
    win_oh = found ? (N'(1) << win_idx) : '0;
  end

endmodule

// File: rtl/oldsel_opnd.sv
module oldsel_opnd #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic [TW-1:0]         win_idx,
  input  logic [N-1:0]          ent_valid,
  input  logic [N-1:0]          src_has,
  input  logic [N-1:0][TW-1:0]  src_id,
  output logic                  from_win,
  output logic [TW-1:0]         prod_tag
);

  logic renamed;
  logic prod_live;

  assign renamed   = src_has[win_idx];
  assign prod_tag  = src_id[win_idx];
  assign prod_live = ent_valid[prod_tag];
  assign from_win  = renamed && prod_live;

endmodule

// File: rtl/oldest_ready_sel.sv
module oldest_ready_sel #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [TW-1:0]         head_ptr,
  input  logic [N-1:0]          ent_valid,
  input  logic [N-1:0]          ent_lock1,
  input  logic [N-1:0]          ent_lock2,
  input  logic [N-1:0]          ent_disp,
  input  logic [N-1:0]          ent_exec,
  input  logic [N-1:0]          ent_store,
  input  logic [N-1:0][1:0]     ent_fu,
  input  logic [N-1:0]          ent_src1_has,
  input  logic [N-1:0][TW-1:0]  ent_src1_id,
  input  logic [N-1:0]          ent_src2_has,
  input  logic [N-1:0][TW-1:0]  ent_src2_id,
  input  logic [2:0]            fu_busy,
  output logic [N-1:0]          grant,
  output logic                  iss_valid,
  output logic [TW-1:0]         iss_tag,
  output logic [1:0]            iss_fu,
  output logic                  iss_src1_win,
  output logic [TW-1:0]         iss_src1_tag,
  output logic                  iss_src2_win,
  output logic [TW-1:0]         iss_src2_tag
);
  localparam int NOPND = 2;

  // Named internal events, visible to the bound checker.
  logic [N-1:0]  ready_vec;
  logic          pick_found;
  logic [TW-1:0] pick_idx;
  logic [N-1:0]  pick_oh;
  logic          dispatch_go;
  logic          idle_cycle;

  logic [NOPND-1:0][N-1:0]         op_has;
  logic [NOPND-1:0][N-1:0][TW-1:0] op_id;
  logic [NOPND-1:0]                op_win;
  logic [NOPND-1:0][TW-1:0]        op_tag;

  oldsel_elig #(.N(N), .TW(TW)) u_elig (
    .head_ptr  (head_ptr),
    .ent_valid (ent_valid),
    .ent_lock1 (ent_lock1),
    .ent_lock2 (ent_lock2),
    .ent_disp  (ent_disp),
    .ent_exec  (ent_exec),
    .ent_store (ent_store),
    .ent_fu    (ent_fu),
    .fu_busy   (fu_busy),
    .ready     (ready_vec)
  );

  oldsel_pick #(.N(N), .TW(TW)) u_pick (
    .ready    (ready_vec),
    .head_ptr (head_ptr),
    .found    (pick_found),
    .win_idx  (pick_idx),
    .win_oh   (pick_oh)
  );

  assign op_has[0] = ent_src1_has;
  assign op_has[1] = ent_src2_has;
  assign op_id[0]  = ent_src1_id;
  assign op_id[1]  = ent_src2_id;

  for (genvar p = 0; p < NOPND; p++) begin : g_opnd
    oldsel_opnd #(.N(N), .TW(TW)) u_opnd (
      .win_idx   (pick_idx),
      .ent_valid (ent_valid),
      .src_has   (op_has[p]),
      .src_id    (op_id[p]),
      .from_win  (op_win[p]),
      .prod_tag  (op_tag[p])
    );
  end

  assign dispatch_go = pick_found && !flush;
  assign idle_cycle  = !dispatch_go;
  assign grant       = dispatch_go ? pick_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid    <= 1'b0;
      iss_tag      <= '0;
      iss_fu       <= '0;
      iss_src1_win <= 1'b0;
      iss_src1_tag <= '0;
      iss_src2_win <= 1'b0;
      iss_src2_tag <= '0;
    end else begin
      iss_valid <= dispatch_go;
      if (dispatch_go) begin
        iss_tag      <= pick_idx;
        iss_fu       <= ent_fu[pick_idx];
        iss_src1_win <= op_win[0];
        iss_src1_tag <= op_tag[0];
        iss_src2_win <= op_win[1];
        iss_src2_tag <= op_tag[1];
      end
    end
  end

endmodule

// File: rtl/oldsel_chk.sv
module oldsel_chk #(
  parameter int N  = 8,
  parameter int TW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [TW-1:0] head_ptr,
  input logic [N-1:0]  ent_valid,
  input logic [N-1:0]  ent_lock1,
  input logic [N-1:0]  ent_lock2,
  input logic [N-1:0]  ent_disp,
  input logic [N-1:0]  ent_exec,
  input logic [N-1:0]  ent_store,
  input logic [N-1:0]  grant,
  input logic          iss_valid,
  input logic [TW-1:0] iss_tag,
  input logic [1:0]    iss_fu
);

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (grant == '0));

  // R1
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & (~ent_valid | ent_lock1 | ent_lock2 | ent_disp | ent_exec)) == '0));

  // R6
  store_at_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ent_store) != '0) |-> grant[head_ptr]);

  // R4
  issue_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (iss_valid && ($past(grant) == (N'(1) << iss_tag))));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> (!iss_valid && $stable(iss_tag) && $stable(iss_fu)));

endmodule

bind oldest_ready_sel oldsel_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .head_ptr  (head_ptr),
  .ent_valid (ent_valid),
  .ent_lock1 (ent_lock1),
  .ent_lock2 (ent_lock2),
  .ent_disp  (ent_disp),
  .ent_exec  (ent_exec),
  .ent_store (ent_store),
  .grant     (grant),
  .iss_valid (iss_valid),
  .iss_tag   (iss_tag),
  .iss_fu    (iss_fu)
);

// File: tb/oldest_ready_sel_tb.sv
module oldest_ready_sel_tb;
  localparam int N  = 8;
  localparam int TW = $clog2(N);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, flush;
  logic [TW-1:0]        head_ptr;
  logic [N-1:0]         ent_valid, ent_lock1, ent_lock2, ent_disp, ent_exec, ent_store;
  logic [N-1:0][1:0]    ent_fu;
  logic [N-1:0]         ent_src1_has, ent_src2_has;
  logic [N-1:0][TW-1:0] ent_src1_id, ent_src2_id;
  logic [2:0]           fu_busy;
  logic [N-1:0]         grant;
  logic                 iss_valid, iss_src1_win, iss_src2_win;
  logic [TW-1:0]        iss_tag, iss_src1_tag, iss_src2_tag;
  logic [1:0]           iss_fu;

  oldest_ready_sel #(.N(N)) u_dut (.*);

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  // Expected issue register, kept by the bench.
  logic          m_valid, m_w1, m_w2;
  logic [TW-1:0] m_tag, m_t1, m_t2;
  logic [1:0]    m_fu;

  task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  // Bench view of qualification (R1, R6).
  function automatic bit can_go(input int e);
    bit unit_free;
    unit_free = (ent_fu[e] != 2'd3) && (fu_busy[ent_fu[e]] == 1'b0);
    if (!ent_valid[e] || ent_disp[e] || ent_exec[e]) return 0;
    if (ent_lock1[e] || ent_lock2[e]) return 0;
    if (ent_store[e] && (e != int'(head_ptr))) return 0;
    return unit_free;
  endfunction

  // Bench view of age order (R2): walk forward from head with wrap.
  function automatic int oldest_ready();
    int e;
    if (flush) return -1;
    e = int'(head_ptr);
    repeat (N) begin
      if (can_go(e)) return e;
      e = (e == N - 1) ? 0 : e + 1;
    end
    return -1;
  endfunction

  task automatic clear_all();
    flush = 0; head_ptr = '0; fu_busy = '0;
    ent_valid = '0; ent_lock1 = '0; ent_lock2 = '0; ent_disp = '0;
    ent_exec = '0; ent_store = '0; ent_fu = '0;
    ent_src1_has = '0; ent_src2_has = '0; ent_src1_id = '0; ent_src2_id = '0;
  endtask

  task automatic rand_fill();
    flush    = ($urandom % 16) == 0;
    head_ptr = TW'($urandom);
    fu_busy  = 3'($urandom & $urandom);
    for (int i = 0; i < N; i++) begin
      ent_valid[i]    = ($urandom % 8) != 0;
      ent_lock1[i]    = ($urandom % 4) == 0;
      ent_lock2[i]    = ($urandom % 4) == 0;
      ent_disp[i]     = ($urandom % 5) == 0;
      ent_exec[i]     = ($urandom % 6) == 0;
      ent_store[i]    = ($urandom % 4) == 0;
      ent_fu[i]       = 2'($urandom);
      ent_src1_has[i] = $urandom % 2;
      ent_src2_has[i] = $urandom % 2;
      ent_src1_id[i]  = TW'($urandom);
      ent_src2_id[i]  = TW'($urandom);
    end
  endtask

  // Called just after a negedge with inputs already driven.
  task automatic run_vec(input string rq);
    int w;
    logic [N-1:0] eg;
    #1;
    w  = oldest_ready();
    eg = (w < 0) ? '0 : (N'(1) << w);
    chk(rq, "grant", 32'(grant), 32'(eg));
    if (w >= 0) begin
      m_valid = 1; m_tag = TW'(w); m_fu = ent_fu[w];
      m_t1 = ent_src1_id[w]; m_t2 = ent_src2_id[w];
      m_w1 = ent_src1_has[w] && ent_valid[ent_src1_id[w]];
      m_w2 = ent_src2_has[w] && ent_valid[ent_src2_id[w]];
    end else begin
      m_valid = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk((w < 0) ? "R7" : "R4", "iss_valid", 32'(iss_valid), 32'(m_valid));
    chk((w < 0) ? "R7" : "R4", "iss_tag",   32'(iss_tag),   32'(m_tag));
    chk((w < 0) ? "R7" : "R4", "iss_fu",    32'(iss_fu),    32'(m_fu));
    chk("R5", "src1_win", 32'(iss_src1_win), 32'(m_w1));
    chk("R5", "src1_tag", 32'(iss_src1_tag), 32'(m_t1));
    chk("R5", "src2_win", 32'(iss_src2_win), 32'(m_w2));
    chk("R5", "src2_tag", 32'(iss_src2_tag), 32'(m_t2));
  endtask

  task automatic all_ready();
    clear_all();
    ent_valid = '1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    clear_all();
    rst_n = 0;
    m_valid = 0; m_tag = '0; m_fu = '0; m_w1 = 0; m_w2 = 0; m_t1 = '0; m_t2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9", "iss_valid", 32'(iss_valid), 0);
    chk("R9", "iss_tag", 32'(iss_tag), 0);
    chk("R9", "iss_fu", 32'(iss_fu), 0);
    chk("R9", "src1_win", 32'(iss_src1_win), 0);
    rst_n = 1;

    // R2 all ready, head=5 -> entry 5
    all_ready(); head_ptr = 3'd5; run_vec("R2");
    // R2 wrap: head=6, only entry 1 ready
    all_ready(); head_ptr = 3'd6; ent_lock1 = ~N'(1 << 1); run_vec("R2");
    // R1 busy load/store class skips entry 3, picks 4
    all_ready(); head_ptr = 3'd3; ent_fu[3] = 2'd1; fu_busy = 3'b010; run_vec("R1");
    // R1 class 3 never qualifies; executed and dispatched entries skipped
    all_ready(); head_ptr = 3'd0; ent_fu[0] = 2'd3; ent_exec[1] = 1; ent_disp[2] = 1; run_vec("R1");
    // R6 store at head dispatches
    all_ready(); head_ptr = 3'd2; ent_store[2] = 1; run_vec("R6");
    // R6 store behind head held; next younger entry wins
    all_ready(); head_ptr = 3'd2; ent_lock2[2] = 1; ent_store[3] = 1; run_vec("R6");
    // R5 producer live vs retired
    all_ready(); head_ptr = 3'd4; ent_valid[1] = 0;
    ent_src1_has[4] = 1; ent_src1_id[4] = 3'd6; ent_src2_has[4] = 1; ent_src2_id[4] = 3'd1;
    run_vec("R5");
    // R7 nothing ready
    all_ready(); ent_lock1 = '1; run_vec("R7");
    // R8 flush
    all_ready(); flush = 1; run_vec("R8");

    for (int v = 0; v < 2000; v++) begin
      rand_fill();
      run_vec("R2");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule